// File: doc/BRIEF.md
# Selectable TDM Slot Transmitter

This block places a fixed group of parallel words onto a shared serial line during chosen time slots of a time-division-multiplexed frame. Each slot lasts one word (16 bit clocks by default) and is sent most significant bit first. A frame sync input starts the frame. The transmitter drives an output-enable only while it owns a slot, so several transmitters can share one line.

Two selects set the layout. The slot select picks which group of three consecutive slots is used. The low group (slots 0 to 2) suits a system with separate input and output wires. The high group (slots 3 to 5) suits a system with one shared data wire. The frame-size select picks a 16-slot frame that carries one sample per sync, or a 32-slot frame that carries two samples per sync. In the 32-slot frame the second sample uses the same slot group, moved 16 slots later. Both selects are captured only when a frame sync is seen, so a new setting takes effect at a frame boundary.

A one-cycle strobe marks each point where the input words are captured for sending. The source can then present the next sample.

Top module: `tdm_slot_tx`

## Requirements
- R1: While reset is asserted, and after reset until the first frame sync, `ser_oe`, `ser_out` and `word_taken` are all 0.
- R2: With `low_slot_sel`=1 captured at a sync, words 0, 1 and 2 are sent in slots 0, 1 and 2. Word k is taken from `tx_words[16k+15:16k]`. The sent bit for frame bit n is word n/16, bit 15-(n mod 16). Frame bit 0 is the bit-clock cycle just after the edge that samples `fsync` high.
- R3: With `low_slot_sel`=0 captured at a sync, words 0, 1 and 2 are sent in slots 3, 4 and 5, which are frame bits 48 to 95, in the same MSB-first order.
- R4: `ser_oe` is 1 only during owned slots of an active frame. Whenever `ser_oe` is 0, `ser_out` is 0.
- R5: With `frame16_sel`=1 captured, a frame is 256 bit clocks long and carries one sample. If no new sync arrives, the block stays silent after bit 255 with no further strobe.
- R6: With `frame16_sel`=0 captured, a frame is 512 bit clocks long and carries two samples. The second sample is sent in the same slot group offset by 16 slots, from words captured at the start of frame bit 256.
- R7: `word_taken` is a one-cycle pulse in the first bit clock of each sample, at frame bits 0 and 256. The words are captured at that point, and later changes to `tx_words` within the sample have no effect on it.
- R8: `frame16_sel` and `low_slot_sel` are sampled only on the edge that sees `fsync` high. Changes in the middle of a frame do not alter that frame.
- R9: A frame sync that arrives before the frame ends restarts the frame at bit 0 of slot 0 and captures fresh words and selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fsync | input | 1 | Frame sync, sampled on the rising edge |
| frame16_sel | input | 1 | 1: 16-slot frame, one sample; 0: 32-slot frame, two samples |
| low_slot_sel | input | 1 | 1: slots 0-2; 0: slots 3-5 |
| tx_words | input | 48 | Three words of one sample, word 0 in the least significant bits |
| ser_out | output | 1 | Serial data, MSB first |
| ser_oe | output | 1 | High while an owned slot is being driven |
| word_taken | output | 1 | One-cycle strobe when a sample's words are captured |

## Verification
Every output is due one register stage after the edge that samples `fsync`. That edge clears the bit position, loads the word hold, latches the selects and sets the strobe, so the first sent bit and the strobe appear in the cycle that follows. The bench therefore drives inputs on the falling edge. It counts frame bit 0 as the first falling edge after the sampling rising edge, and from there records one value per bit clock. Each recorded bit n is compared with a model of slot n/16 and bit 15-(n mod 16). The second-sample capture and strobe fall on recorded bit 256. Sixteen further bits past the frame end confirm the line is silent.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;
   // captured frame layout, updated only at a frame sync
   typedef struct packed {
      logic frame16;   // 1: one sample per frame
      logic low_slots; // 1: slot group starting at slot 0
   } tx_mode_t;
endpackage

// File: rtl/tdm_bit_counter.sv
module tdm_bit_counter #(
   parameter int POS_W     = 9,
   parameter int HALF_BITS = 256
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fsync,
   input  logic             frame16,
   output logic [POS_W-1:0] pos,
   output logic             active,
   output logic             sample_start
);
   localparam logic [POS_W-1:0] LAST_SHORT = POS_W'(HALF_BITS - 1);
   localparam logic [POS_W-1:0] LAST_LONG  = POS_W'(2*HALF_BITS - 1);

   logic [POS_W-1:0] last_pos;
   assign last_pos = frame16 ? LAST_SHORT : LAST_LONG;

   // capture point: frame start, or the half boundary of a long frame
   assign sample_start = fsync | (active & ~frame16 & (pos == LAST_SHORT));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos    <= '0;
         active <= 1'b0;
      end else if (fsync) begin
         pos    <= '0;
         active <= 1'b1;
      end else if (active) begin
         if (pos == last_pos) active <= 1'b0;
         else                 pos    <= pos + 1'b1;
      end
   end
endmodule

// File: rtl/tdm_slot_owner.sv
module tdm_slot_owner #(
   parameter int SLOT_W    = 4,
   parameter int NUM_WORDS = 3,
   parameter int IDX_W     = 2,
   parameter int LO_BASE   = 0,
   parameter int HI_BASE   = 3
) (
   input  logic [SLOT_W-1:0] slot,
   input  logic              low_slots,
   output logic              owned,
   output logic [IDX_W-1:0]  word_idx
);
   logic [NUM_WORDS-1:0] hit;

   for (genvar k = 0; k < NUM_WORDS; k++) begin : g_hit
      localparam logic [SLOT_W-1:0] LO_SLOT = SLOT_W'(LO_BASE + k);
      localparam logic [SLOT_W-1:0] HI_SLOT = SLOT_W'(HI_BASE + k);
      assign hit[k] = (slot == (low_slots ? LO_SLOT : HI_SLOT));
   end

   always_comb begin
      owned    = |hit;
      word_idx = '0;
      for (int k = 0; k < NUM_WORDS; k++)
         if (hit[k]) word_idx = IDX_W'(k);
   end
endmodule

// File: rtl/tdm_word_hold.sv
module tdm_word_hold #(
   parameter int WORD_W    = 16,
   parameter int NUM_WORDS = 3,
   parameter int IDX_W     = 2,
   parameter int BIT_W     = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        load,
   input  logic [NUM_WORDS*WORD_W-1:0] words,
   input  logic [IDX_W-1:0]            word_idx,
   input  logic [BIT_W-1:0]            bit_idx,
   output logic                        bit_out,
   output logic                        taken
);
   logic [WORD_W-1:0] hold_q [NUM_WORDS];

   for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
      always_ff @(posedge clk) begin
         if (!rst_n)    hold_q[g] <= '0;
         else if (load) hold_q[g] <= words[g*WORD_W +: WORD_W];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) taken <= 1'b0;
      else        taken <= load;
   end

   // MSB first: bit position WORD_W-1-bit_idx equals ~bit_idx for power-of-two widths
   always_comb begin
      bit_out = 1'b0;
      for (int k = 0; k < NUM_WORDS; k++)
         if (word_idx == IDX_W'(k)) bit_out = hold_q[k][~bit_idx];
   end
endmodule

// File: rtl/tdm_slot_tx.sv
module tdm_slot_tx #(
   parameter int WORD_W           = 16,
   parameter int NUM_WORDS        = 3,
   parameter int SLOTS_PER_SAMPLE = 16,
   parameter int LO_BASE          = 0,
   parameter int HI_BASE          = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        fsync,
   input  logic                        frame16_sel,
   input  logic                        low_slot_sel,
   input  logic [NUM_WORDS*WORD_W-1:0] tx_words,
   output logic                        ser_out,
   output logic                        ser_oe,
   output logic                        word_taken
);
   import tdm_tx_pkg::*;

   localparam int BIT_W     = $clog2(WORD_W);
   localparam int SLOT_W    = $clog2(SLOTS_PER_SAMPLE);
   localparam int POS_W     = BIT_W + SLOT_W + 1;
   localparam int HALF_BITS = WORD_W * SLOTS_PER_SAMPLE;
   localparam int IDX_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

   if ((1 << BIT_W) != WORD_W) begin : g_bad_word
      $error("WORD_W must be a power of two");
   end
   if ((1 << SLOT_W) != SLOTS_PER_SAMPLE) begin : g_bad_slots
      $error("SLOTS_PER_SAMPLE must be a power of two");
   end
   if (LO_BASE + NUM_WORDS > SLOTS_PER_SAMPLE || HI_BASE + NUM_WORDS > SLOTS_PER_SAMPLE) begin : g_bad_base
      $error("slot group exceeds the sample");
   end

   tx_mode_t mode_q;
   always_ff @(posedge clk) begin
      if (!rst_n)     mode_q <= '0;
      else if (fsync) mode_q <= '{frame16: frame16_sel, low_slots: low_slot_sel};
   end

   logic [POS_W-1:0] pos;
   logic             active, sample_start;

   tdm_bit_counter #(.POS_W(POS_W), .HALF_BITS(HALF_BITS)) u_cnt (
      .clk          (clk),
      .rst_n        (rst_n),
      .fsync        (fsync),
      .frame16      (mode_q.frame16),
      .pos          (pos),
      .active       (active),
      .sample_start (sample_start)
   );

   logic             owned;
   logic [IDX_W-1:0] word_idx;

   tdm_slot_owner #(
      .SLOT_W(SLOT_W), .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W),
      .LO_BASE(LO_BASE), .HI_BASE(HI_BASE)
   ) u_own (
      .slot      (pos[BIT_W +: SLOT_W]),
      .low_slots (mode_q.low_slots),
      .owned     (owned),
      .word_idx  (word_idx)
   );

   logic bit_val;

   tdm_word_hold #(
      .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W), .BIT_W(BIT_W)
   ) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (sample_start),
      .words    (tx_words),
      .word_idx (word_idx),
      .bit_idx  (pos[BIT_W-1:0]),
      .bit_out  (bit_val),
      .taken    (word_taken)
   );

   assign ser_oe  = active & owned;
   assign ser_out = ser_oe & bit_val;
endmodule

// File: rtl/tdm_slot_tx_chk.sv
module tdm_slot_tx_chk #(
   parameter int WORD_W    = 16,
   parameter int NUM_WORDS = 3
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        fsync,
   input logic                        low_slot_sel,
   input logic [NUM_WORDS*WORD_W-1:0] tx_words,
   input logic                        ser_out,
   input logic                        ser_oe,
   input logic                        word_taken
);
   AST_SYNC_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      fsync |=> word_taken); // R7
   AST_STROBE_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
      (word_taken && !fsync) |=> !word_taken); // R7
   AST_LOW_FIRST_OE: assert property (@(posedge clk) disable iff (!rst_n)
      (fsync && low_slot_sel) |=> ser_oe); // R2
   AST_LOW_FIRST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (fsync && low_slot_sel) |=> (ser_out == $past(tx_words[WORD_W-1]))); // R2
   AST_HIGH_SILENT_START: assert property (@(posedge clk) disable iff (!rst_n)
      (fsync && !low_slot_sel) |=> !ser_oe); // R3
   AST_QUIET_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      !ser_oe |-> !ser_out); // R4
endmodule

bind tdm_slot_tx tdm_slot_tx_chk #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .fsync        (fsync),
   .low_slot_sel (low_slot_sel),
   .tx_words     (tx_words),
   .ser_out      (ser_out),
   .ser_oe       (ser_oe),
   .word_taken   (word_taken)
);

// File: tb/tb_tdm_slot_tx.sv
module tb_tdm_slot_tx;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fsync = 1'b0;
   logic        frame16_sel = 1'b1;
   logic        low_slot_sel = 1'b1;
   logic [47:0] tx_words = '0;
   logic        ser_out, ser_oe, word_taken;

   int checks = 0;
   int errors = 0;

   logic got_d  [0:599];
   logic got_oe [0:599];
   logic got_tk [0:599];
   logic [47:0] exp_w0, exp_w1;

   always #2.5 clk = ~clk;

   tdm_slot_tx dut (
      .clk(clk), .rst_n(rst_n), .fsync(fsync),
      .frame16_sel(frame16_sel), .low_slot_sel(low_slot_sel),
      .tx_words(tx_words), .ser_out(ser_out), .ser_oe(ser_oe),
      .word_taken(word_taken)
   );

   initial begin
      #(5.0 * 200000);
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   task automatic do_sync();
      @(negedge clk) fsync = 1'b1;
      @(negedge clk) fsync = 1'b0;
   endtask

   // records len bits starting at frame bit 0; optional mid-frame input change
   task automatic collect(int len, int chg_n, logic [47:0] chg_w, logic chg_f16, logic chg_low);
      for (int n = 0; n < len; n++) begin
         got_d[n]  = ser_out;
         got_oe[n] = ser_oe;
         got_tk[n] = word_taken;
         if (n == chg_n) begin
            tx_words     = chg_w;
            frame16_sel  = chg_f16;
            low_slot_sel = chg_low;
         end
         @(negedge clk);
      end
   endtask

   task automatic check_frame(string req, int len, logic f16, logic low);
      int flen, bad_d, bad_o, bad_t;
      flen = f16 ? 256 : 512;
      bad_d = 0; bad_o = 0; bad_t = 0;
      for (int n = 0; n < len; n++) begin
         int s, h, base, bi;
         logic eo, ed, et;
         logic [47:0] w;
         h    = n / 256;
         s    = (n % 256) / 16;
         base = low ? 0 : 3;
         bi   = 15 - (n % 16);
         w    = (h == 0) ? exp_w0 : exp_w1;
         eo   = (n < flen) && (s >= base) && (s < base + 3);
         ed   = eo ? w[(s - base)*16 + bi] : 1'b0;
         et   = (n < flen) && (n % 256 == 0);
         if (got_oe[n] !== eo) begin
            if (bad_o == 0) $display("FAIL %s oe bit %0d: actual=%b expected=%b", req, n, got_oe[n], eo);
            bad_o++;
         end
         if (got_d[n] !== ed) begin
            if (bad_d == 0) $display("FAIL %s data bit %0d: actual=%b expected=%b", req, n, got_d[n], ed);
            bad_d++;
         end
         if (got_tk[n] !== et) begin
            if (bad_t == 0) $display("FAIL %s strobe bit %0d: actual=%b expected=%b", req, n, got_tk[n], et);
            bad_t++;
         end
      end
      checks += 3;
      if (bad_o != 0) errors++;
      if (bad_d != 0) errors++;
      if (bad_t != 0) errors++;
   endtask

   task automatic check_idle(string req);
      checks++;
      if (ser_oe !== 1'b0 || ser_out !== 1'b0 || word_taken !== 1'b0) begin
         errors++;
         $display("FAIL %s idle: actual=%b%b%b expected=000", req, ser_oe, ser_out, word_taken);
      end
   endtask

   task automatic t_reset();   // R1
      repeat (3) @(negedge clk);
      check_idle("R1");
      rst_n = 1'b1;
      repeat (20) begin
         @(negedge clk);
         check_idle("R1");
      end
   endtask

   task automatic t_low_slots();   // R2 R4 R5 R7
      frame16_sel = 1'b1; low_slot_sel = 1'b1;
      tx_words = 48'hA5C3_0F0F_8001;
      exp_w0 = tx_words;
      do_sync();
      collect(272, -1, '0, 1'b1, 1'b1);
      check_frame("R2", 272, 1'b1, 1'b1);
   endtask

   task automatic t_high_slots();   // R3 R4
      frame16_sel = 1'b1; low_slot_sel = 1'b0;
      tx_words = 48'h1234_FFFF_7E81;
      exp_w0 = tx_words;
      do_sync();
      collect(272, -1, '0, 1'b1, 1'b0);
      check_frame("R3", 272, 1'b1, 1'b0);
   endtask

   task automatic t_frame16_end();   // R5
      frame16_sel = 1'b1; low_slot_sel = 1'b1;
      tx_words = 48'hFFFF_FFFF_FFFF;
      exp_w0 = tx_words;
      do_sync();
      collect(300, -1, '0, 1'b1, 1'b1);
      check_frame("R5", 300, 1'b1, 1'b1);
   endtask

   task automatic t_frame32();   // R6 R7
      frame16_sel = 1'b0; low_slot_sel = 1'b0;
      tx_words = 48'hC001_5A5A_0003;
      exp_w0 = tx_words;
      exp_w1 = 48'h3FFE_A5A4_F00D;
      do_sync();
      collect(528, 100, exp_w1, 1'b0, 1'b0);
      check_frame("R6", 528, 1'b0, 1'b0);
      frame16_sel = 1'b0; low_slot_sel = 1'b1;
      tx_words = 48'h0F0F_F0F0_9999;
      exp_w0 = tx_words;
      exp_w1 = 48'h6666_0001_8000;
      do_sync();
      collect(528, 3, exp_w1, 1'b0, 1'b1);
      check_frame("R7", 528, 1'b0, 1'b1);
   endtask

   task automatic t_mode_hold();   // R8
      frame16_sel = 1'b1; low_slot_sel = 1'b1;
      tx_words = 48'hBEEF_CAFE_1357;
      exp_w0 = tx_words;
      do_sync();
      collect(272, 5, 48'hBEEF_CAFE_1357, 1'b0, 1'b0);
      check_frame("R8", 272, 1'b1, 1'b1);
      exp_w0 = tx_words;
      exp_w1 = tx_words;
      do_sync();
      collect(528, -1, '0, 1'b0, 1'b0);
      check_frame("R8", 528, 1'b0, 1'b0);
   endtask

   task automatic t_early();   // R9
      frame16_sel = 1'b1; low_slot_sel = 1'b0;
      tx_words = 48'hAAAA_5555_AAAA;
      do_sync();
      repeat (70) @(negedge clk);
      tx_words = 48'h0123_4567_89AB;
      exp_w0 = tx_words;
      do_sync();
      collect(272, -1, '0, 1'b1, 1'b0);
      check_frame("R9", 272, 1'b1, 1'b0);
   endtask

   initial begin
      t_reset();
      t_low_slots();
      t_high_slots();
      t_frame16_end();
      t_frame32();
      t_mode_hold();
      t_early();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule